// File: doc/BRIEF.md
# In-Frame Response Request Qualifier

This block sits between the host and the symbol layer of a byte-level serial link controller for a vehicle network that uses variable pulse width coding. The host writes transmit opcodes, and the block decides whether each opcode may turn into a byte on the bus. Message opcodes are held in a one-deep queue until the symbol layer reports that the bus is free. An in-frame response opcode is judged at once against the receive status of the frame in progress. If accepted, it overrides any queued message. If refused, it raises a sticky error flag.

Two response kinds are handled. A type 2 response sends one byte, taken from the physical-address input. A type 3 response sends a string of bytes, each taken from the transmit-data input. Each byte of a type 3 string needs its own opcode write, and the last byte of the string asks for the CRC to be appended. Once a string is running, later bytes are checked only against the byte-count limit and against transmitter activity. When the transmitter is left short of data, the block tells the symbol layer to close the frame with an inverted CRC.

Top module: `ifr_qualifier`

## Requirements
- R1: Opcodes use a 3-bit code: 1 message, 2 message+CRC, 4 type 2 response, 5 type 3 response, 6 type 3 response+CRC. No other code has any effect. When a type 2 response is accepted, `tx_start` is high for exactly one cycle, in the cycle after the write, with `tx_byte` equal to `phys_addr` and `tx_add_crc` low.
- R2: An accepted type 3 opcode sends `tx_data`. Code 6 sets `tx_add_crc` and clears `ifr_string`. Code 5 clears `tx_add_crc` and leaves `ifr_string` high.
- R3: If the first response byte arrives while `rx_crc_ok` is low, `crc_err` is set and no byte starts.
- R4: If `len_chk_en` is high and `rx_len_ok` is low, a first response byte is refused and `tx_abort` is set. If `len_chk_en` is low, `rx_len_ok` has no effect.
- R5: If `rx_eod_ok` is low, a first response byte is refused and no flag changes.
- R6: When `no_len_limit` is low, a type 2 response needs `rx_byte_cnt` of 11 or less and a type 3 byte needs 9 or less; otherwise it is refused and `tx_abort` is set. When `no_len_limit` is high, the count is not checked.
- R7: A response opcode written while a message is being sent sets `tx_abort` and `tx_underflow`, and pulses `tx_inv_crc` for one cycle.
- R8: A response opcode written while a response byte is being sent, or while `rx_in_ifr` is high, sets `tx_abort` only.
- R9: A queued message starts on `msg_go` when the transmitter is idle, sending `tx_data`. An accepted response clears the queued message, so a later `msg_go` starts nothing.
- R10: While a type 3 string is running, later bytes ignore the CRC, length and end-of-data status. A later byte over the count limit sets `tx_abort` and `tx_underflow`, pulses `tx_inv_crc`, and ends the string.
- R11: The flags are sticky. `flag_clr` bit 0 clears `crc_err`, bit 1 clears `tx_abort` and bit 2 clears `tx_underflow`. A flag being set in the same cycle as its clear stays set.
- R12: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_wr | input | 1 | Opcode write strobe |
| op_code | input | 3 | Opcode value |
| tx_data | input | DW | Transmit-data register contents |
| phys_addr | input | DW | Physical-address register contents |
| rx_crc_ok | input | 1 | Received CRC is valid |
| rx_len_ok | input | 1 | Received length is valid |
| len_chk_en | input | 1 | Length checking enabled |
| rx_eod_ok | input | 1 | Valid end-of-data minimum symbol seen |
| rx_in_ifr | input | 1 | An in-frame response portion is being received |
| no_len_limit | input | 1 | Disables the byte-count limit |
| rx_byte_cnt | input | CNT_W | Bytes received in the current frame |
| msg_go | input | 1 | Bus free for a queued message |
| tx_byte_done | input | 1 | Symbol layer finished the current byte |
| flag_clr | input | 3 | Write-1-to-clear for the flags |
| tx_start | output | 1 | One-cycle byte start pulse |
| tx_byte | output | DW | Byte to send |
| tx_add_crc | output | 1 | Append the CRC after this byte |
| tx_inv_crc | output | 1 | Close the frame with an inverted CRC |
| ifr_string | output | 1 | Type 3 string in progress |
| crc_err | output | 1 | Sticky CRC-error flag |
| tx_abort | output | 1 | Sticky request-aborted flag |
| tx_underflow | output | 1 | Sticky data-underflow flag |

## Verification
The assertions check the following on every cycle:
- a start pulse lasts one cycle and never coincides with an inverted-CRC request;
- an inverted CRC always comes with the underflow flag, and underflow never rises without the abort flag;
- a first response refused for a bad CRC starts nothing;
- a type 2 response over the count limit starts nothing;
- an accepted type 2 byte carries the physical address.

Only the bench scenarios can show the following:
- the priority order among the refusal reasons;
- the override of a queued message;
- the relaxed checks on later string bytes;
- that a refusal with end-of-data missing leaves every flag untouched.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  localparam logic [2:0] OP_MSG      = 3'd1;
  localparam logic [2:0] OP_MSG_CRC  = 3'd2;
  localparam logic [2:0] OP_IFR2     = 3'd4;
  localparam logic [2:0] OP_IFR3     = 3'd5;
  localparam logic [2:0] OP_IFR3_CRC = 3'd6;

  localparam int NFLAG = 3;
  localparam int FL_CRC = 0;
  localparam int FL_ABT = 1;
  localparam int FL_UF  = 2;

  typedef enum logic [1:0] {EX_IDLE, EX_MSG, EX_IFR} exec_t;

  typedef struct packed {
    logic start;
    logic set_crc;
    logic set_abort;
    logic set_uf;
    logic end_string;
  } verdict_t;
endpackage

// File: rtl/ifr_gate.sv
module ifr_gate import ifr_pkg::*; #(
  parameter int CNT_W  = 5,
  parameter int T2_MAX = 11,
  parameter int T3_MAX = 9
) (
  input  logic             op_wr,
  input  logic [2:0]       op_code,
  input  exec_t            exec,
  input  logic             string_on,
  input  logic             rx_crc_ok,
  input  logic             rx_len_ok,
  input  logic             len_chk_en,
  input  logic             rx_eod_ok,
  input  logic             rx_in_ifr,
  input  logic             no_len_limit,
  input  logic [CNT_W-1:0] rx_byte_cnt,
  output verdict_t         verdict
);
  localparam logic [CNT_W-1:0] T2_LIM = CNT_W'(T2_MAX);
  localparam logic [CNT_W-1:0] T3_LIM = CNT_W'(T3_MAX);

  function automatic logic count_ok(input logic [CNT_W-1:0] cnt,
                                    input logic [CNT_W-1:0] lim,
                                    input logic nfl);
    return nfl || (cnt <= lim);
  endfunction

  logic is_t2, is_t3, is_rsp, cnt_fits;

  always_comb begin
    is_t2    = (op_code == OP_IFR2);
    is_t3    = (op_code == OP_IFR3) || (op_code == OP_IFR3_CRC);
    is_rsp   = is_t2 || is_t3;
    cnt_fits = count_ok(rx_byte_cnt, is_t2 ? T2_LIM : T3_LIM, no_len_limit);
    verdict  = '0;
    if (op_wr && is_rsp) begin
      if (string_on) begin
        if (!is_t3 || exec != EX_IDLE) begin
          verdict.set_abort = 1'b1;
        end else if (!cnt_fits) begin
          verdict.set_abort  = 1'b1;
          verdict.set_uf     = 1'b1;
          verdict.end_string = 1'b1;
        end else begin
          verdict.start      = 1'b1;
          verdict.end_string = (op_code == OP_IFR3_CRC);
        end
      end else if (exec == EX_MSG) begin
        verdict.set_abort = 1'b1;
        verdict.set_uf    = 1'b1;
      end else if (exec == EX_IFR || rx_in_ifr) begin
        verdict.set_abort = 1'b1;
      end else if (!rx_crc_ok) begin
        verdict.set_crc = 1'b1;
      end else if (len_chk_en && !rx_len_ok) begin
        verdict.set_abort = 1'b1;
      end else if (!rx_eod_ok) begin
        verdict.start = 1'b0;
      end else if (!cnt_fits) begin
        verdict.set_abort = 1'b1;
      end else begin
        verdict.start = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ifr_flags.sv
module ifr_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o[i] <= 1'b0;
      else        flag_o[i] <= set_i[i] | (flag_o[i] & ~clr_i[i]);
    end
  end
endmodule

// File: rtl/ifr_qualifier.sv
module ifr_qualifier import ifr_pkg::*; #(
  parameter int DW     = 8,
  parameter int CNT_W  = 5,
  parameter int T2_MAX = 11,
  parameter int T3_MAX = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_wr,
  input  logic [2:0]       op_code,
  input  logic [DW-1:0]    tx_data,
  input  logic [DW-1:0]    phys_addr,
  input  logic             rx_crc_ok,
  input  logic             rx_len_ok,
  input  logic             len_chk_en,
  input  logic             rx_eod_ok,
  input  logic             rx_in_ifr,
  input  logic             no_len_limit,
  input  logic [CNT_W-1:0] rx_byte_cnt,
  input  logic             msg_go,
  input  logic             tx_byte_done,
  input  logic [2:0]       flag_clr,
  output logic             tx_start,
  output logic [DW-1:0]    tx_byte,
  output logic             tx_add_crc,
  output logic             tx_inv_crc,
  output logic             ifr_string,
  output logic             crc_err,
  output logic             tx_abort,
  output logic             tx_underflow
);
  exec_t          exec;
  logic           msg_pending, msg_crc;
  verdict_t       verdict;
  logic           msg_launch, is_msg_op;
  logic           exec_busy;
  logic           req_start;
  logic [NFLAG-1:0] flag_set, flag_q;

  ifr_gate #(.CNT_W(CNT_W), .T2_MAX(T2_MAX), .T3_MAX(T3_MAX)) u_gate (
    .op_wr(op_wr), .op_code(op_code), .exec(exec), .string_on(ifr_string),
    .rx_crc_ok(rx_crc_ok), .rx_len_ok(rx_len_ok), .len_chk_en(len_chk_en),
    .rx_eod_ok(rx_eod_ok), .rx_in_ifr(rx_in_ifr), .no_len_limit(no_len_limit),
    .rx_byte_cnt(rx_byte_cnt), .verdict(verdict)
  );

  assign exec_busy  = (exec != EX_IDLE);
  assign req_start  = verdict.start;
  assign is_msg_op  = op_wr && (op_code == OP_MSG || op_code == OP_MSG_CRC);
  assign msg_launch = msg_pending && msg_go && !exec_busy && !ifr_string && !op_wr;

  always_comb begin
    flag_set         = '0;
    flag_set[FL_CRC] = verdict.set_crc;
    flag_set[FL_ABT] = verdict.set_abort;
    flag_set[FL_UF]  = verdict.set_uf;
  end

  ifr_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr), .flag_o(flag_q)
  );

  assign crc_err      = flag_q[FL_CRC];
  assign tx_abort     = flag_q[FL_ABT];
  assign tx_underflow = flag_q[FL_UF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec        <= EX_IDLE;
      ifr_string  <= 1'b0;
      msg_pending <= 1'b0;
      msg_crc     <= 1'b0;
      tx_start    <= 1'b0;
      tx_byte     <= '0;
      tx_add_crc  <= 1'b0;
      tx_inv_crc  <= 1'b0;
    end else begin
      tx_start   <= 1'b0;
      tx_inv_crc <= verdict.set_uf;
      if (verdict.start) begin
        tx_start    <= 1'b1;
        tx_byte     <= (op_code == OP_IFR2) ? phys_addr : tx_data;
        tx_add_crc  <= (op_code == OP_IFR3_CRC);
        exec        <= EX_IFR;
        msg_pending <= 1'b0;
        ifr_string  <= (op_code == OP_IFR3);
      end else if (msg_launch) begin
        tx_start    <= 1'b1;
        tx_byte     <= tx_data;
        tx_add_crc  <= msg_crc;
        exec        <= EX_MSG;
        msg_pending <= 1'b0;
      end else begin
        if (tx_byte_done) exec <= EX_IDLE;
        if (verdict.end_string) ifr_string <= 1'b0;
        if (is_msg_op) begin
          msg_pending <= 1'b1;
          msg_crc     <= (op_code == OP_MSG_CRC);
        end
      end
    end
  end
endmodule

// File: rtl/ifr_qualifier_chk.sv
module ifr_qualifier_chk #(
  parameter int DW     = 8,
  parameter int CNT_W  = 5,
  parameter int T2_MAX = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_wr,
  input logic [2:0]       op_code,
  input logic [DW-1:0]    phys_addr,
  input logic             rx_crc_ok,
  input logic             rx_in_ifr,
  input logic             no_len_limit,
  input logic [CNT_W-1:0] rx_byte_cnt,
  input logic             exec_busy,
  input logic             tx_start,
  input logic [DW-1:0]    tx_byte,
  input logic             tx_inv_crc,
  input logic             ifr_string,
  input logic             crc_err,
  input logic             tx_abort,
  input logic             tx_underflow
);
  localparam logic [CNT_W-1:0] T2_LIM = CNT_W'(T2_MAX);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start); // R1
  AST_IFR2_BYTE_IS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && op_code == 3'd4 && !ifr_string && !exec_busy) |=>
      (!tx_start || tx_byte == $past(phys_addr))); // R1
  AST_CRC_BAD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && op_code == 3'd4 && !rx_crc_ok && !ifr_string && !exec_busy && !rx_in_ifr) |=>
      (!tx_start && crc_err)); // R3
  AST_T2_OVER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && op_code == 3'd4 && !no_len_limit && rx_byte_cnt > T2_LIM) |=> !tx_start); // R6
  AST_INV_CRC_WITH_UF: assert property (@(posedge clk) disable iff (!rst_n)
    tx_inv_crc |-> tx_underflow); // R7
  AST_UF_WITH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_underflow) |-> tx_abort); // R7
  AST_NO_START_AND_INV: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_start && tx_inv_crc)); // R10
endmodule

bind ifr_qualifier ifr_qualifier_chk #(.DW(DW), .CNT_W(CNT_W), .T2_MAX(T2_MAX)) u_chk (.*);

// File: tb/ifr_qualifier_tb.sv
module ifr_qualifier_tb;
  localparam int DW = 8;
  localparam int CNT_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_wr = 0; logic [2:0] op_code = 0;
  logic [DW-1:0] tx_data = 8'h3C, phys_addr = 8'hA5;
  logic rx_crc_ok = 1, rx_len_ok = 1, len_chk_en = 0, rx_eod_ok = 1, rx_in_ifr = 0;
  logic no_len_limit = 0; logic [CNT_W-1:0] rx_byte_cnt = 5;
  logic msg_go = 0, tx_byte_done = 0; logic [2:0] flag_clr = 0;
  logic tx_start, tx_add_crc, tx_inv_crc, ifr_string, crc_err, tx_abort, tx_underflow;
  logic [DW-1:0] tx_byte;

  int errors = 0, checks = 0, cycles = 0;
  logic s_start, s_crc, s_inv; logic [DW-1:0] s_byte;

  always #5 clk = ~clk;

  ifr_qualifier u_dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [2:0] clr = 3'b0);
    @(negedge clk); op_wr = 1; op_code = op; flag_clr = clr;
    @(negedge clk); op_wr = 0; flag_clr = 0;
    s_start = tx_start; s_byte = tx_byte; s_crc = tx_add_crc; s_inv = tx_inv_crc;
  endtask

  task automatic byte_done();
    @(negedge clk); tx_byte_done = 1;
    @(negedge clk); tx_byte_done = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 3'b111;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic flags_are(input string tag, input logic [2:0] exp);
    check(tag, {tx_underflow, tx_abort, crc_err}, exp);
  endtask

  task automatic t_reset();
    check("R12 outputs after reset",
          {tx_start, tx_add_crc, tx_inv_crc, ifr_string, crc_err, tx_abort, tx_underflow}, 0);
  endtask

  task automatic t_ifr2();
    do_op(3'd4);
    check("R1 start", s_start, 1);
    check("R1 byte from address", s_byte, 8'hA5);
    check("R1 no crc", s_crc, 0);
    @(negedge clk); check("R1 single pulse", tx_start, 0);
    byte_done();
    do_op(3'd7); check("R1 unused code no start", s_start, 0);
    flags_are("R1 unused code no flag", 0);
  endtask

  task automatic t_ifr3_string();
    tx_data = 8'h11; do_op(3'd5);
    check("R2 first byte", {s_start, s_byte, s_crc}, {1'b1, 8'h11, 1'b0});
    check("R2 string on", ifr_string, 1);
    byte_done();
    rx_crc_ok = 0; rx_eod_ok = 0; len_chk_en = 1; rx_len_ok = 0; tx_data = 8'h22;
    do_op(3'd5);
    check("R10 later byte ignores status", {s_start, s_byte}, {1'b1, 8'h22});
    flags_are("R10 no flags", 0);
    byte_done();
    tx_data = 8'h33; do_op(3'd6);
    check("R2 last byte", {s_start, s_byte, s_crc}, {1'b1, 8'h33, 1'b1});
    check("R2 string off", ifr_string, 0);
    byte_done();
    rx_crc_ok = 1; rx_eod_ok = 1; len_chk_en = 0; rx_len_ok = 1;
  endtask

  task automatic t_crc_bad();
    rx_crc_ok = 0; do_op(3'd4);
    check("R3 no start", s_start, 0);
    flags_are("R3 crc flag", 3'b001);
    clear_flags(); flags_are("R11 cleared", 0);
    rx_crc_ok = 1;
  endtask

  task automatic t_len();
    len_chk_en = 1; rx_len_ok = 0; do_op(3'd4);
    check("R4 refused", s_start, 0); flags_are("R4 abort", 3'b010);
    clear_flags();
    len_chk_en = 0; do_op(3'd4);
    check("R4 ignored when disabled", s_start, 1);
    byte_done(); rx_len_ok = 1;
  endtask

  task automatic t_eod();
    rx_eod_ok = 0; do_op(3'd5);
    check("R5 refused", s_start, 0); flags_are("R5 no flags", 0);
    check("R5 no string", ifr_string, 0);
    rx_eod_ok = 1;
  endtask

  task automatic t_limits();
    rx_byte_cnt = 11; do_op(3'd4); check("R6 type2 at 11", s_start, 1); byte_done();
    rx_byte_cnt = 12; do_op(3'd4); check("R6 type2 at 12", s_start, 0);
    flags_are("R6 abort type2", 3'b010); clear_flags();
    rx_byte_cnt = 9; do_op(3'd6); check("R6 type3 at 9", s_start, 1); byte_done();
    rx_byte_cnt = 10; do_op(3'd6); check("R6 type3 at 10", s_start, 0);
    flags_are("R6 abort type3", 3'b010); clear_flags();
    no_len_limit = 1; rx_byte_cnt = 20; do_op(3'd4);
    check("R6 limit off", s_start, 1); byte_done();
    no_len_limit = 0; rx_byte_cnt = 5;
  endtask

  task automatic t_msg();
    tx_data = 8'h5A; do_op(3'd1);
    check("R9 queued waits", s_start, 0);
    @(negedge clk); msg_go = 1; @(negedge clk); msg_go = 0;
    check("R9 message starts", {tx_start, tx_byte, tx_add_crc}, {1'b1, 8'h5A, 1'b0});
    do_op(3'd4);
    check("R7 no start", s_start, 0);
    check("R7 inverted crc pulse", s_inv, 1);
    flags_are("R7 abort and underflow", 3'b110);
    @(negedge clk); check("R7 inv pulse one cycle", tx_inv_crc, 0);
    byte_done(); clear_flags();
  endtask

  task automatic t_override();
    do_op(3'd2); do_op(3'd4);
    check("R9 response overrides", {s_start, s_byte}, {1'b1, 8'hA5});
    byte_done();
    @(negedge clk); msg_go = 1; @(negedge clk); msg_go = 0;
    check("R9 queue cleared", tx_start, 0);
  endtask

  task automatic t_busy();
    do_op(3'd4); check("R8 first starts", s_start, 1);
    do_op(3'd5); check("R8 busy refused", s_start, 0);
    flags_are("R8 abort only", 3'b010);
    byte_done(); clear_flags();
    rx_in_ifr = 1; do_op(3'd4);
    check("R8 rx ifr refused", s_start, 0); flags_are("R8 abort rx ifr", 3'b010);
    rx_in_ifr = 0; clear_flags();
  endtask

  task automatic t_cont_over();
    do_op(3'd5); check("R10 string start", s_start, 1); byte_done();
    rx_byte_cnt = 10; do_op(3'd5);
    check("R10 over limit no start", s_start, 0);
    check("R10 inverted crc", s_inv, 1);
    flags_are("R10 abort underflow", 3'b110);
    check("R10 string ended", ifr_string, 0);
    rx_byte_cnt = 5; clear_flags();
  endtask

  task automatic t_sticky();
    rx_crc_ok = 0; do_op(3'd4);
    repeat (3) @(negedge clk);
    flags_are("R11 sticky", 3'b001);
    do_op(3'd4, 3'b001);
    flags_are("R11 set wins over clear", 3'b001);
    @(negedge clk); flag_clr = 3'b110; @(negedge clk); flag_clr = 0;
    flags_are("R11 other bits do not clear", 3'b001);
    rx_crc_ok = 1; clear_flags();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_ifr2();
    t_ifr3_string();
    t_crc_bad();
    t_len();
    t_eod();
    t_limits();
    t_msg();
    t_override();
    t_busy();
    t_cont_over();
    t_sticky();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule